// File: doc/BRIEF.md
# Link-Side Status Shifter With Abortable Transfer

This block sits on the physical-layer side of a serial bus interface. It keeps a word of status flags and shifts that word to the link controller two bits per clock over a 2-bit control bus and a 2-bit data bus. A transfer is either short (the low four flags) or full (all sixteen flags). The length is chosen with the request. Each flag is cleared once it has been delivered, so a flag raised again later is reported by a later transfer.

Packet reception has priority over status reporting. When a receive-start indication arrives during a transfer, the block drops the status code from the control bus in that same cycle and ends the transfer. It then clears only the low flags that already went out. It re-queues the transfer when the rules call for it: a full transfer is always retried, and a short one only while one of its four flags is still set. A retry, or a request that arrives while the block is busy or while a reception is starting, is held until the block is free. It then starts on the first cycle in which no reception is signalled.

Top module: `phy_status_xfer`

## Requirements
- R1: After reset, ctl_o is 00, data_o is 00, busy_o is 0, and all sixteen status flags are 0.
- R2: A 1 on stat_set_i[i] sets flag i at the next clock edge. A set in the same cycle as the clear of that flag wins, so the flag stays 1.
- R3: A request with xfer_long_i=0 that is accepted in an idle cycle is followed, from the next cycle on, by exactly two status cycles k=0,1. In each of them ctl_o=01, data_o[0]=flag[2k], data_o[1]=flag[2k+1] and busy_o=1. The cycle after them has ctl_o=00 and busy_o=0.
- R4: A request with xfer_long_i=1 gives eight status cycles k=0..7 with the same code and lane mapping as in R3.
- R5: A transfer that completes clears every flag it delivered. Flags 0..3 are cleared at the edge that ends their cycle, and flags 4..15 at the edge that ends the last cycle of a full transfer.
- R6: A 1 on rx_start_i during a status cycle forces ctl_o=00 and data_o=00 in that same cycle. busy_o falls at the next edge.
- R7: After an abort, only the delivered pairs among flags 0..3 are cleared. After pair 0 alone, flags 0..1 are cleared and flags 2..3 are kept. After two or more pairs, flags 0..3 are cleared. Flags 4..15 are always kept.
- R8: An aborted full transfer is always retried as a full transfer, starting again from pair 0.
- R9: An aborted short transfer is retried only if at least one of flags 0..3 is still 1 after the abort. Otherwise no transfer follows.
- R10: No transfer starts in a cycle with rx_start_i=1. A request or retry that is pending, or a request made while busy, starts in the first idle cycle with rx_start_i=0, and the status cycles begin one cycle later.
- R11: data_o is 00 whenever ctl_o is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stat_set_i | input | 16 | Per-flag set pulses |
| xfer_req_i | input | 1 | Transfer request pulse |
| xfer_long_i | input | 1 | Length select with the request: 1 = sixteen flags, 0 = four flags |
| rx_start_i | input | 1 | Reception is starting; aborts a transfer and blocks starts |
| ctl_o | output | 2 | Control code: 00 idle, 01 status |
| data_o | output | 2 | Status pair: bit 0 carries the even flag, bit 1 the odd flag |
| busy_o | output | 1 | A transfer is in progress |

## Verification
Completed transfers of both lengths run with asymmetric flag patterns, so a swapped lane or a wrong pair order shows up in the data. A second transfer after each one shows that the delivered flags were cleared. Aborts after one, two and four delivered pairs, and in the very first cycle, separate the two clearing rules and show that flags above bit 3 survive. The short-transfer aborts use one pattern with flags left in 2..3 and one with none left, which tells a conditional retry apart from an unconditional one. A set pulse that lands on a clearing edge, requests made during a reception and during a transfer, and the retry timing after the receive indication drops cover the set priority and the start rules.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE   = 2'b00,
    CTL_STATUS = 2'b01
  } ctl_code_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SHIFT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/stat_bank.sv
module stat_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] bits_o
);
  logic [W-1:0] bits_q, bits_d;
  logic         upd_en;

  // set has priority over clear
  always_comb begin
    bits_d = (bits_q & ~clr_i) | set_i;
    upd_en = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits_q <= '0;
    else if (upd_en) bits_q <= bits_d;
  end

  assign bits_o = bits_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_chk
      assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> bits_o[i]);
      assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !bits_o[i]);
    end
  endgenerate

  assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(bits_o));
endmodule

// File: rtl/retry_ctl.sv
module retry_ctl #(
  parameter int SHORT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic               req_long_i,
  input  logic               abort_i,
  input  logic               abort_long_i,
  input  logic [SHORT_W-1:0] low_bits_i,
  input  logic               start_i,
  output logic               want_o,
  output logic               want_long_o
);
  logic pend_q, pend_d;
  logic pend_long_q, pend_long_d;
  logic retry;
  logic pend_en;

  always_comb begin
    retry       = abort_i && (abort_long_i || (|low_bits_i));
    pend_d      = ((pend_q || req_i) && !start_i) || retry;
    pend_long_d = start_i ? 1'b0
                          : (pend_long_q || (req_i && req_long_i) || (retry && abort_long_i));
    pend_en     = req_i || start_i || abort_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_long_q <= 1'b0;
    end else if (pend_en) begin
      pend_q      <= pend_d;
      pend_long_q <= pend_long_d;
    end
  end

  assign want_o      = pend_q || req_i;
  assign want_long_o = pend_long_q || (req_i && req_long_i);

  assert_long_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && abort_long_i) |=> (pend_q && pend_long_q));
  assert_short_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !abort_long_i && low_bits_i == '0 && !pend_q && !req_i) |=> !pend_q);
  assert_short_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && (low_bits_i != '0)) |=> pend_q);
  assert_start_consumes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !abort_i) |=> !pend_q || $past(req_i && 1'b0));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import phy_stat_pkg::*;
#(
  parameter int W       = 16,
  parameter int SHORT_W = 4,
  parameter int LANES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want_i,
  input  logic             want_long_i,
  input  logic             rx_i,
  input  logic [W-1:0]     bits_i,
  output logic [1:0]       ctl_o,
  output logic [LANES-1:0] data_o,
  output logic             busy_o,
  output logic [W-1:0]     clr_o,
  output logic             start_o,
  output logic             abort_o,
  output logic             abort_long_o
);
  localparam int PAIRS_L = W / LANES;
  localparam int PAIRS_S = SHORT_W / LANES;
  localparam int CNTW    = (PAIRS_L > 1) ? $clog2(PAIRS_L) : 1;
  localparam int IW      = (W > 1) ? $clog2(W) : 1;

  seq_state_e      state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            long_q, long_d;
  logic            seq_en;
  logic            shift_now;
  logic            last_now;
  logic [CNTW-1:0] last_idx;

  always_comb begin
    last_idx  = long_q ? CNTW'(PAIRS_L - 1) : CNTW'(PAIRS_S - 1);
    shift_now = (state_q == SEQ_SHIFT) && !rx_i;
    last_now  = shift_now && (cnt_q == last_idx);
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    long_d  = long_q;
    start_o = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (want_i && !rx_i) begin
          state_d = SEQ_SHIFT;
          cnt_d   = '0;
          long_d  = want_long_i;
          start_o = 1'b1;
        end
      end
      SEQ_SHIFT: begin
        if (rx_i || (cnt_q == last_idx)) state_d = SEQ_IDLE;
        else                             cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
    seq_en = start_o || (state_q == SEQ_SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      long_q  <= 1'b0;
    end else if (seq_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      long_q  <= long_d;
    end
  end

  // lane drive
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [IW-1:0] idx;
      assign idx       = IW'(IW'(cnt_q) * IW'(LANES)) + IW'(l);
      assign data_o[l] = shift_now && bits_i[idx];
    end
  endgenerate

  // clear mask: low pairs as delivered, upper pairs on full completion
  generate
    for (genvar p = 0; p < PAIRS_L; p++) begin : g_pair
      for (genvar l = 0; l < LANES; l++) begin : g_bit
        if (p < PAIRS_S) begin : g_early
          assign clr_o[p*LANES+l] = shift_now && (cnt_q == CNTW'(p));
        end else begin : g_late
          assign clr_o[p*LANES+l] = last_now && long_q;
        end
      end
    end
  endgenerate

  assign ctl_o        = shift_now ? CTL_STATUS : CTL_IDLE;
  assign busy_o       = (state_q == SEQ_SHIFT);
  assign abort_o      = (state_q == SEQ_SHIFT) && rx_i;
  assign abort_long_o = long_q;

  assert_abort_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rx_i) |-> (ctl_o == CTL_IDLE));
  assert_abort_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rx_i) |=> !busy_o);
  assert_fresh_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (cnt_q == '0));
  assert_short_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rx_i && !long_q && cnt_q == CNTW'(PAIRS_S - 1)) |=> !busy_o);
  assert_long_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rx_i && long_q && cnt_q != CNTW'(PAIRS_L - 1)) |=> busy_o);
  assert_no_start_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && rx_i) |=> !busy_o);
  assert_data_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o == CTL_IDLE) |-> (data_o == '0));
endmodule

// File: rtl/phy_status_xfer.sv
module phy_status_xfer #(
  parameter int STAT_W  = 16,
  parameter int SHORT_W = 4,
  parameter int LANES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_set_i,
  input  logic              xfer_req_i,
  input  logic              xfer_long_i,
  input  logic              rx_start_i,
  output logic [1:0]        ctl_o,
  output logic [LANES-1:0]  data_o,
  output logic              busy_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [STAT_W-1:0] stat_bits;
  logic [STAT_W-1:0] stat_clr;
  logic              want, want_long, start, abort, abort_long;
  logic [SHORT_W-1:0] low_after;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  stat_bank #(.W(STAT_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (stat_set_i),
    .clr_i  (stat_clr),
    .bits_o (stat_bits)
  );

  // no clear happens in an abort cycle, so set pulses give the post-abort value
  assign low_after = stat_bits[SHORT_W-1:0] | stat_set_i[SHORT_W-1:0];

  retry_ctl #(.SHORT_W(SHORT_W)) u_retry (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .req_i        (xfer_req_i),
    .req_long_i   (xfer_long_i),
    .abort_i      (abort),
    .abort_long_i (abort_long),
    .low_bits_i   (low_after),
    .start_i      (start),
    .want_o       (want),
    .want_long_o  (want_long)
  );

  xfer_seq #(.W(STAT_W), .SHORT_W(SHORT_W), .LANES(LANES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .want_i       (want),
    .want_long_i  (want_long),
    .rx_i         (rx_start_i),
    .bits_i       (stat_bits),
    .ctl_o        (ctl_o),
    .data_o       (data_o),
    .busy_o       (busy_o),
    .clr_o        (stat_clr),
    .start_o      (start),
    .abort_o      (abort),
    .abort_long_o (abort_long)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_int_n |=> (!busy_o || !rst_int_n));
endmodule

// File: tb/tb_phy_status_xfer.sv
`timescale 1ns/1ps
module tb_phy_status_xfer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] stat_set_i;
  logic        xfer_req_i, xfer_long_i, rx_start_i;
  logic [1:0]  ctl_o, data_o;
  logic        busy_o;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;

  always #5 clk = ~clk;

  phy_status_xfer dut (
    .clk(clk), .rst_n(rst_n), .stat_set_i(stat_set_i), .xfer_req_i(xfer_req_i),
    .xfer_long_i(xfer_long_i), .rx_start_i(rx_start_i), .ctl_o(ctl_o),
    .data_o(data_o), .busy_o(busy_o)
  );

  task automatic step();
    @(negedge clk); #1;
  endtask

  // value packed as {ctl, data, busy}
  task automatic chk(input string r, input logic [4:0] exp);
    logic [4:0] act;
    #1;
    act = {ctl_o, data_o, busy_o};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ctl/data/busy got %b expected %b", r, act, exp);
    end
  endtask

  task automatic set_status(input logic [15:0] v);
    stat_set_i = v; step(); stat_set_i = '0;
  endtask

  task automatic start(input logic lng);
    xfer_req_i = 1'b1; xfer_long_i = lng; step();
    xfer_req_i = 1'b0; xfer_long_i = 1'b0;
  endtask

  // checks pairs first..last-1 of s, one per cycle
  task automatic run_pairs(input int first, input int last, input logic [15:0] s, input string r);
    for (int k = first; k < last; k++) begin
      chk(r, {2'b01, s[2*k+1], s[2*k], 1'b1});
      step();
    end
  endtask

  task automatic chk_idle(input string r);
    chk(r, 5'b00000);
  endtask

  task automatic abort_now(input string r);
    rx_start_i = 1'b1;
    chk(r, 5'b00001);
    step();
  endtask

  task automatic release_rx(input string r);
    chk(r, 5'b00000);
    rx_start_i = 1'b0;
    chk(r, 5'b00000);
    step();
  endtask

  task automatic t_reset();
    chk_idle("R1 idle outputs after reset");
    start(1'b1);
    run_pairs(0, 8, 16'h0000, "R1 flags zero after reset");
    chk_idle("R1 idle after transfer");
  endtask

  task automatic t_short_complete();
    set_status(16'h000B);
    start(1'b0);
    run_pairs(0, 2, 16'h000B, "R3 short pairs");
    chk_idle("R3 short ends after two cycles");
    start(1'b0);
    run_pairs(0, 2, 16'h0000, "R5 short clears delivered flags");
    chk_idle("R3 idle");
  endtask

  task automatic t_long_complete();
    set_status(16'hA5C3);
    start(1'b1);
    run_pairs(0, 8, 16'hA5C3, "R4 long pairs");
    chk_idle("R4 long ends after eight cycles");
    start(1'b1);
    run_pairs(0, 8, 16'h0000, "R5 long clears all flags");
    chk_idle("R4 idle");
  endtask

  task automatic t_abort_2bits_short();
    set_status(16'h000E);
    start(1'b0);
    run_pairs(0, 1, 16'h000E, "R3 pair0 before abort");
    abort_now("R6 abort quiet in same cycle");
    chk("R10 no start while rx high", 5'b00000);
    step();
    release_rx("R6 busy dropped after abort");
    run_pairs(0, 2, 16'h000C, "R7 R9 retry after 2 bits");
    chk_idle("R9 retry done");
  endtask

  task automatic t_short_no_retry();
    set_status(16'h0003);
    start(1'b0);
    run_pairs(0, 1, 16'h0003, "R3 pair0");
    abort_now("R6 abort quiet");
    release_rx("R9 idle at release");
    for (int i = 0; i < 4; i++) begin
      chk("R9 no retry when low flags clear", 5'b00000);
      step();
    end
  endtask

  task automatic t_abort_4bits_long();
    set_status(16'hFFFF);
    start(1'b1);
    run_pairs(0, 2, 16'hFFFF, "R4 pairs before abort");
    abort_now("R6 abort after 4 bits");
    release_rx("R6 busy dropped");
    run_pairs(0, 8, 16'hFFF0, "R7 R8 retry after 4 bits");
    chk_idle("R8 retry done");
  endtask

  task automatic t_abort_8bits_long();
    set_status(16'h5A5F);
    start(1'b1);
    run_pairs(0, 4, 16'h5A5F, "R4 pairs before abort");
    abort_now("R6 abort after 8 bits");
    chk("R10 held by rx", 5'b00000);
    step();
    release_rx("R6 busy dropped");
    run_pairs(0, 8, 16'h5A50, "R7 R8 retry after 8 bits keeps upper flags");
    chk_idle("R8 retry done");
  endtask

  task automatic t_abort_first_cycle();
    set_status(16'h0003);
    start(1'b1);
    abort_now("R6 abort before any pair");
    release_rx("R6 busy dropped");
    run_pairs(0, 8, 16'h0003, "R7 R8 nothing cleared without delivery");
    chk_idle("R8 retry done");
  endtask

  task automatic t_req_during_rx();
    rx_start_i = 1'b1;
    start(1'b0);
    for (int i = 0; i < 3; i++) begin
      chk("R10 request held while rx high", 5'b00000);
      step();
    end
    rx_start_i = 1'b0;
    chk("R10 idle at release", 5'b00000);
    step();
    run_pairs(0, 2, 16'h0000, "R10 held request starts");
    chk_idle("R10 done");
  endtask

  task automatic t_req_during_busy();
    set_status(16'h0009);
    start(1'b0);
    xfer_req_i = 1'b1; xfer_long_i = 1'b1;
    run_pairs(0, 1, 16'h0009, "R10 short pair0");
    xfer_req_i = 1'b0; xfer_long_i = 1'b0;
    run_pairs(1, 2, 16'h0009, "R10 short pair1");
    chk("R10 one idle cycle before queued start", 5'b00000);
    step();
    run_pairs(0, 8, 16'h0000, "R10 queued long request runs");
    chk_idle("R10 done");
  endtask

  task automatic t_set_wins();
    start(1'b1);
    stat_set_i = 16'h0002;
    run_pairs(0, 1, 16'h0000, "R2 pair0");
    stat_set_i = '0;
    run_pairs(1, 8, 16'h0000, "R2 rest");
    chk_idle("R2 idle");
    start(1'b0);
    run_pairs(0, 2, 16'h0002, "R2 set beats clear on same edge");
    chk_idle("R2 done");
  endtask

  initial begin
    rst_n = 1'b0; stat_set_i = '0; xfer_req_i = 1'b0; xfer_long_i = 1'b0; rx_start_i = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_short_complete();
    t_long_complete();
    t_abort_2bits_short();
    t_short_no_retry();
    t_abort_4bits_long();
    t_abort_8bits_long();
    t_abort_first_cycle();
    t_req_during_rx();
    t_req_during_busy();
    t_set_wins();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule